// File: doc/BRIEF.md
# PCI Type-0 Configuration Address Translator

This block sits behind a CPU-side window reserved for configuration cycles toward the secondary PCI bus. For each access it receives the offset into the window, the access width and the lower bits of the configuration-map register. It builds a 32-bit intermediate address from the map bits and the offset. It reads the one-hot device-select field out of that address and produces a standard configuration address: enable bit, bus, device, function and register. A single registered stage holds the result.

Some accesses cannot be translated. These are a request for a type-1 cycle, an empty device-select field, a misaligned halfword or word, and a reserved width code. For each of them the block reports an error and drives the all-ones code instead of an address. After every access that translates cleanly, it emits a one-cycle pulse. Downstream logic uses that pulse to clear the received-master-abort and received-target-abort bits in the bridge's own configuration status word.

Top module: `cfg_addr_xlate`

## Requirements
- R1: Each cycle with `req_valid` high produces `out_valid` high in the following cycle only; a cycle without a request gives `out_valid`, `out_err` and `clr_abort` low in the following cycle.
- R2: When `map_cfg[16]` is 1 (type-1 request), the result has `out_err` high and `out_addr` equal to 0xFFFFFFFF.
- R3: The intermediate address is {`map_cfg[15:0]`, `req_offset[15:0]`}. When its bits [31:11] are all zero, the result is an error with `out_addr` 0xFFFFFFFF.
- R4: The device number in `out_addr[15:11]` is the index, counting from 0, of the lowest set bit among intermediate bits [31:11]. Higher set bits are ignored.
- R5: `out_addr[10:8]` carries intermediate bits [10:8]. `out_addr[7:0]` carries intermediate bits [7:0] masked with 0xFC, so bits [1:0] are always 0.
- R6: A good result has bit 31 set, bits [30:24] zero and `bus_num` in bits [23:16].
- R7: `req_size` encodes 00 byte, 01 halfword, 10 word and 11 reserved. A halfword with offset bit 0 set, a word with offset bits [1:0] nonzero, or the reserved code produces an error with `out_addr` 0xFFFFFFFF. A byte access is never misaligned.
- R8: `clr_abort` is high exactly in the cycles where `out_valid` is high and `out_err` is low.
- R9: While `rst_n` is low, `out_valid`, `out_err` and `clr_abort` are 0 and `out_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access presented this cycle |
| req_offset | input | 16 | Low offset bits of the access in the window |
| req_size | input | 2 | Access width code (00 byte, 01 half, 10 word, 11 reserved) |
| map_cfg | input | 17 | Low bits of the configuration-map register; bit 16 requests type 1 |
| bus_num | input | 8 | Number of the bus being addressed |
| out_valid | output | 1 | Result available |
| out_err | output | 1 | Access rejected |
| out_addr | output | 32 | Translated configuration address or 0xFFFFFFFF |
| clr_abort | output | 1 | Pulse to clear the received-abort status bits |

## Verification
The bench sets several device-select bits at once. A design that searched from the top, or one that treated the field as a binary count, would return the wrong device number. It also drives the top device-select bit alone, which catches an encoder one bit short. Offsets with their low two bits set are sent as byte, halfword and word accesses. A translator that skipped the mask would leak those bits into the register field, and a wrong alignment rule would reject good accesses or accept bad ones. Type-1 requests, empty select fields and back-to-back requests mixing good and bad results confirm that the abort-clear pulse never follows a rejected access.

// File: rtl/cax_pkg.sv
package cax_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;

    localparam int unsigned CFG_W   = 32;
    localparam int unsigned SEL_LO  = 11;
    localparam int unsigned SEL_W   = CFG_W - SEL_LO;
    localparam int unsigned DEV_W   = $clog2(SEL_W);
    localparam logic [CFG_W-1:0] BAD_CODE = '1;

    typedef struct packed {
        logic             vld;
        logic             err;
        logic             clr;
        logic [CFG_W-1:0] addr;
    } xl_state_t;
endpackage

// File: rtl/lsb_encoder.sv
module lsb_encoder #(
    parameter int unsigned W     = 21,
    localparam int unsigned IDXW = $clog2(W)
) (
    input  logic [W-1:0]    bits_i,
    output logic            found_o,
    output logic [IDXW-1:0] idx_o
);
    always_comb begin
        idx_o = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (bits_i[i]) begin
                idx_o = IDXW'(i);
            end
        end
    end

    assign found_o = |bits_i;
endmodule

// File: rtl/size_align.sv
module size_align
    import cax_pkg::*;
(
    input  acc_size_e   size_i,
    input  logic [1:0]  low_i,
    output logic        bad_o
);
    always_comb begin
        unique case (size_i)
            SZ_BYTE: bad_o = 1'b0;
            SZ_HALF: bad_o = low_i[0];
            SZ_WORD: bad_o = |low_i;
            default: bad_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/xlate_core.sv
module xlate_core
    import cax_pkg::*;
#(
    parameter int unsigned BUS_W = 8
) (
    input  logic [15:0]      off_i,
    input  acc_size_e        size_i,
    input  logic [16:0]      map_i,
    input  logic [BUS_W-1:0] bus_i,
    output logic [CFG_W-1:0] addr_o,
    output logic             err_o
);
    logic [CFG_W-1:0] cfg;
    logic             sel_hit;
    logic [DEV_W-1:0] dev;
    logic             misalign;

    assign cfg = {map_i[15:0], off_i};

    lsb_encoder #(.W(SEL_W)) u_enc (
        .bits_i  (cfg[CFG_W-1:SEL_LO]),
        .found_o (sel_hit),
        .idx_o   (dev)
    );

    size_align u_align (
        .size_i (size_i),
        .low_i  (off_i[1:0]),
        .bad_o  (misalign)
    );

    assign err_o = map_i[16] | ~sel_hit | misalign;

    always_comb begin
        addr_o        = '0;
        addr_o[31]    = 1'b1;
        addr_o[16 +: BUS_W] = bus_i;
        addr_o[15:11] = 5'(dev);
        addr_o[10:8]  = cfg[10:8];
        addr_o[7:2]   = cfg[7:2];
    end
endmodule

// File: rtl/cfg_addr_xlate.sv
module cfg_addr_xlate
    import cax_pkg::*;
#(
    parameter int unsigned BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [15:0]      req_offset,
    input  logic [1:0]       req_size,
    input  logic [16:0]      map_cfg,
    input  logic [BUS_W-1:0] bus_num,
    output logic             out_valid,
    output logic             out_err,
    output logic [31:0]      out_addr,
    output logic             clr_abort
);
    xl_state_t        st_d, st_q;
    logic [CFG_W-1:0] xl_addr;
    logic             xl_err;

    xlate_core #(.BUS_W(BUS_W)) u_core (
        .off_i  (req_offset),
        .size_i (acc_size_e'(req_size)),
        .map_i  (map_cfg),
        .bus_i  (bus_num),
        .addr_o (xl_addr),
        .err_o  (xl_err)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = req_valid;
        st_d.err = req_valid & xl_err;
        st_d.clr = req_valid & ~xl_err;
        if (req_valid) begin
            st_d.addr = xl_err ? BAD_CODE : xl_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_err   = st_q.err;
    assign out_addr  = st_q.addr;
    assign clr_abort = st_q.clr;
endmodule

// File: rtl/cfg_addr_xlate_chk.sv
module cfg_addr_xlate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [15:0] req_offset,
    input logic [1:0]  req_size,
    input logic [16:0] map_cfg,
    input logic        out_valid,
    input logic        out_err,
    input logic [31:0] out_addr,
    input logic        clr_abort
);
    AST_REQ_GIVES_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid); // R1
    AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !out_valid && !out_err && !clr_abort); // R1
    AST_TYPE1_REJECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && map_cfg[16]) |=> (out_err && out_addr == 32'hFFFF_FFFF)); // R2
    AST_EMPTY_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && map_cfg[15:0] == 16'h0 && req_offset[15:11] == 5'h0) |=> out_err); // R3
    AST_GOOD_LAYOUT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_err) |-> (out_addr[31] && out_addr[30:24] == 7'h0 && out_addr[1:0] == 2'b00)); // R6
    AST_WORD_MISALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size == 2'b10 && req_offset[1:0] != 2'b00) |=> out_err); // R7
    AST_CLEAR_ONLY_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
        clr_abort == (out_valid && !out_err)); // R8
endmodule

bind cfg_addr_xlate cfg_addr_xlate_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_offset (req_offset),
    .req_size   (req_size),
    .map_cfg    (map_cfg),
    .out_valid  (out_valid),
    .out_err    (out_err),
    .out_addr   (out_addr),
    .clr_abort  (clr_abort)
);

// File: tb/sim_cfg_addr_xlate.sv
module sim_cfg_addr_xlate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_offset = '0;
    logic [1:0]  req_size = '0;
    logic [16:0] map_cfg = '0;
    logic [7:0]  bus_num = '0;
    logic        out_valid, out_err, clr_abort;
    logic [31:0] out_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cfg_addr_xlate u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_offset(req_offset),
        .req_size(req_size), .map_cfg(map_cfg), .bus_num(bus_num),
        .out_valid(out_valid), .out_err(out_err), .out_addr(out_addr), .clr_abort(clr_abort)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [15:0] off, input logic [1:0] sz,
                         input logic [16:0] map, input logic [7:0] bus);
        req_valid  = 1'b1;
        req_offset = off;
        req_size   = sz;
        map_cfg    = map;
        bus_num    = bus;
    endtask

    task automatic expect_res(input string tag, input bit bad, input logic [31:0] addr);
        chk({tag, " valid"}, 32'(out_valid), 32'd1);
        chk({tag, " err"}, 32'(out_err), 32'(bad));
        chk({tag, " R8 clr"}, 32'(clr_abort), 32'(!bad));
        chk({tag, " addr"}, out_addr, bad ? 32'hFFFF_FFFF : addr);
    endtask

    task automatic one_req(input string tag, input logic [15:0] off, input logic [1:0] sz,
                           input logic [16:0] map, input logic [7:0] bus,
                           input bit bad, input logic [31:0] addr);
        @(negedge clk);
        drive(off, sz, map, bus);
        @(negedge clk);
        req_valid = 1'b0;
        expect_res(tag, bad, addr);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R9 valid", 32'(out_valid), 32'd0);
        chk("R9 err", 32'(out_err), 32'd0);
        chk("R9 clr", 32'(clr_abort), 32'd0);
        chk("R9 addr", out_addr, 32'd0);
    endtask

    task automatic t_basic;
        // dev 6 from intermediate bit 17, func 5, reg 0x08, bus 3
        one_req("R4 R5 R6 basic", 16'h0508, 2'b10, 17'h00002, 8'h03, 1'b0, 32'h8003_3508);
        // bits 11 and 12 and map bit 22 set: lowest wins -> dev 0, func 2
        one_req("R4 lowest bit", 16'h1A04, 2'b01, 17'h00040, 8'h7F, 1'b0, 32'h807F_0204);
        // only intermediate bit 31 -> dev 20
        one_req("R4 top bit", 16'h0000, 2'b00, 17'h08000, 8'hFF, 1'b0, 32'h80FF_A000);
    endtask

    task automatic t_mask;
        one_req("R5 byte low bits", 16'h0803, 2'b00, 17'h00000, 8'h01, 1'b0, 32'h8001_0000);
        one_req("R7 half aligned", 16'h0802, 2'b01, 17'h00000, 8'h00, 1'b0, 32'h8000_0000);
    endtask

    task automatic t_errors;
        one_req("R2 type1", 16'h0508, 2'b10, 17'h10002, 8'h03, 1'b1, 32'h0);
        one_req("R3 empty select", 16'h07FC, 2'b10, 17'h00000, 8'h03, 1'b1, 32'h0);
        one_req("R7 half misaligned", 16'h0801, 2'b01, 17'h00000, 8'h00, 1'b1, 32'h0);
        one_req("R7 word misaligned", 16'h0802, 2'b10, 17'h00000, 8'h00, 1'b1, 32'h0);
        one_req("R7 reserved size", 16'h0800, 2'b11, 17'h00000, 8'h00, 1'b1, 32'h0);
    endtask

    task automatic t_idle;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        chk("R1 idle valid", 32'(out_valid), 32'd0);
        chk("R1 idle err", 32'(out_err), 32'd0);
        chk("R8 idle clr", 32'(clr_abort), 32'd0);
    endtask

    task automatic t_back_to_back;
        @(negedge clk);
        drive(16'h0508, 2'b10, 17'h00002, 8'h03);
        @(negedge clk);
        expect_res("R1 b2b first", 1'b0, 32'h8003_3508);
        drive(16'h0000, 2'b10, 17'h00000, 8'h03);
        @(negedge clk);
        expect_res("R1 b2b second", 1'b1, 32'h0);
        drive(16'h0800, 2'b10, 17'h00000, 8'h09);
        @(negedge clk);
        req_valid = 1'b0;
        expect_res("R1 b2b third", 1'b0, 32'h8009_0000);
        @(negedge clk);
        chk("R1 b2b end", 32'(out_valid), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_basic();
        t_mask();
        t_errors();
        t_idle();
        t_back_to_back();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog expired actual=running expected=done");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule